// File: doc/BRIEF.md
# Ring and Line-Reversal Guard Timer

This block watches a pulse line that an external isolation circuit toggles while the telephone line rings or after the line polarity reverses. The block keeps a line-activity status bit. Any rising edge on the pulse line pulls the status bit low. The bit goes high again only once the line has stayed quiet for a programmable guard interval. The guard interval is counted in prescaled ticks taken from the system clock. The length is `4*G + 3` ticks, where `G` is a 7-bit setting. With the default divide of 512 on a 3.579545 MHz clock, each tick is about 143 µs, so `G = 60` gives about 34.7 ms.

When its interrupt enable is set, the block raises a sticky flag on every change of the status bit. A processor reading its interrupt register clears the flag by pulsing the read-clear input. Ringing shows up as a status bit that stays low for the length of each burst. A line reversal shows up as a single low interval of one guard time.

Top module: `lr_guard_timer`

## Requirements
- R1: After reset the status output is 1 and the flag output is 0.
- R2: The pulse input passes through two synchronizing flops. A rising edge on it pulls the status low on the third rising clock edge at which the input is seen high. A falling edge or a steady level on the pulse input has no effect on the status.
- R3: After a detected rising edge, the status returns to 1 on the clock edge of the (4*G+3)-th tick that follows the edge, where G is `guard_sel`. A tick that falls in the same cycle as the edge is not counted.
- R4: `tick_o` is high for one cycle out of every PRESCALE cycles. It is first high in the PRESCALE-th cycle after reset is released.
- R5: A new rising edge while the status is low restarts the guard count from zero.
- R6: While `irq_en` is 1, every change of the status sets the flag on the same clock edge.
- R7: While `irq_en` is 0, status changes leave the flag unchanged.
- R8: A one-cycle `rd_clr` clears the flag on the next clock edge. If a flag set and `rd_clr` fall in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pulse_i | input | 1 | Asynchronous ring/reversal pulse line |
| guard_sel | input | 7 | Guard setting G; the guard interval is 4*G+3 ticks |
| irq_en | input | 1 | Enables setting the flag on status changes |
| rd_clr | input | 1 | Clear-on-read strobe for the flag |
| status_o | output | 1 | Line-activity status: 0 while edges are recent |
| flag_o | output | 1 | Sticky interrupt flag |
| tick_o | output | 1 | Prescaled guard tick |

## Verification
The hardest case to reach is a status rise that falls in the very cycle in which software clears the flag. The clear must lose to the new set. The exact cycle depends on where the tick falls relative to the last pulse edge. The stimulus therefore holds `rd_clr` high over the whole window in which the rise can happen, so that the collision is certain to occur. A cycle-accurate model in the bench follows the same window and checks the result. Pulse trains that arrive faster than the guard interval exercise the restart of the count. Switching `irq_en` mid-burst shows that transitions with the enable off leave the flag unchanged.

// File: rtl/lrg_pkg.sv
package lrg_pkg;
  localparam int GUARD_W = 7;
  localparam int CNT_W   = GUARD_W + 2;

  // Guard length in ticks: 4*G + 3
  function automatic logic [CNT_W-1:0] guard_ticks(input logic [GUARD_W-1:0] g);
    return {g, 2'b00} + CNT_W'(3);
  endfunction
endpackage

// File: rtl/lrg_sync_edge.sv
module lrg_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= {pipe_q[STAGES-1:0], async_i};
  end

  // pipe_q[STAGES-1] is the synchronized level, pipe_q[STAGES] its delayed copy
  assign rise_o = pipe_q[STAGES-1] & ~pipe_q[STAGES];
endmodule

// File: rtl/lrg_prescaler.sv
module lrg_prescaler #(
  parameter int DIV = 512
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  generate
    if (DIV <= 1) begin : g_pass
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int PW = $clog2(DIV);
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);
      logic [PW-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
      end
      assign tick_o = (cnt_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/lrg_guard_core.sv
module lrg_guard_core
  import lrg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rise_i,
  input  logic               tick_i,
  input  logic [GUARD_W-1:0] guard_sel,
  input  logic               irq_en,
  input  logic               rd_clr,
  output logic               status_o,
  output logic               flag_o,
  output logic               set_evt_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d, limit;
  logic             status_q, status_d, flag_q;

  assign limit = guard_ticks(guard_sel);

  always_comb begin
    status_d = status_q;
    cnt_d    = cnt_q;
    if (rise_i) begin
      status_d = 1'b0;
      cnt_d    = '0;
    end else if (!status_q && tick_i) begin
      if (CNT_W'(cnt_q + 1'b1) >= limit) begin
        status_d = 1'b1;
        cnt_d    = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  assign set_evt_o = irq_en & (status_d ^ status_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= 1'b1;
      cnt_q    <= '0;
      flag_q   <= 1'b0;
    end else begin
      status_q <= status_d;
      cnt_q    <= cnt_d;
      if (set_evt_o)   flag_q <= 1'b1;
      else if (rd_clr) flag_q <= 1'b0;
    end
  end

  assign status_o = status_q;
  assign flag_o   = flag_q;
endmodule

// File: rtl/lr_guard_timer.sv
module lr_guard_timer
  import lrg_pkg::*;
#(
  parameter int PRESCALE    = 512,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pulse_i,
  input  logic [GUARD_W-1:0] guard_sel,
  input  logic               irq_en,
  input  logic               rd_clr,
  output logic               status_o,
  output logic               flag_o,
  output logic               tick_o
);
  logic rise_evt;
  logic tick_evt;
  logic set_evt;

  lrg_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(pulse_i), .rise_o(rise_evt)
  );

  lrg_prescaler #(.DIV(PRESCALE)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick_o(tick_evt)
  );

  lrg_guard_core u_core (
    .clk(clk), .rst_n(rst_n), .rise_i(rise_evt), .tick_i(tick_evt),
    .guard_sel(guard_sel), .irq_en(irq_en), .rd_clr(rd_clr),
    .status_o(status_o), .flag_o(flag_o), .set_evt_o(set_evt)
  );

  assign tick_o = tick_evt;
endmodule

// File: rtl/lrg_chk.sv
module lrg_chk #(
  parameter int DIV = 512
) (
  input logic clk,
  input logic rst_n,
  input logic rise_evt,
  input logic tick_evt,
  input logic set_evt,
  input logic status_o,
  input logic flag_o,
  input logic irq_en,
  input logic rd_clr
);
  // R2
  edge_drops_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_evt |=> !status_o);

  // R3
  rise_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_o) |-> $past(tick_evt));

  // R6
  change_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_o != $past(status_o)) && $past(irq_en)) |-> flag_o);

  // R7
  disabled_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(irq_en) && !$past(flag_o)) |-> !flag_o);

  // R8
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !set_evt) |=> !flag_o);

  generate
    if (DIV > 1) begin : g_tick
      // R4
      tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_evt |=> !tick_evt);
    end
  endgenerate
endmodule

bind lr_guard_timer lrg_chk #(.DIV(PRESCALE)) u_chk (
  .clk(clk), .rst_n(rst_n), .rise_evt(rise_evt), .tick_evt(tick_evt),
  .set_evt(set_evt), .status_o(status_o), .flag_o(flag_o),
  .irq_en(irq_en), .rd_clr(rd_clr)
);

// File: tb/lr_guard_timer_test.sv
`timescale 1ns/1ps
module lr_guard_timer_test;
  localparam int PRE = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pulse_i = 1'b0;
  logic [6:0] guard_sel = 7'd0;
  logic       irq_en = 1'b0;
  logic       rd_clr = 1'b0;
  logic       status_o, flag_o, tick_o;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 1'b0;

  lr_guard_timer #(.PRESCALE(PRE)) uut (
    .clk(clk), .rst_n(rst_n), .pulse_i(pulse_i), .guard_sel(guard_sel),
    .irq_en(irq_en), .rd_clr(rd_clr),
    .status_o(status_o), .flag_o(flag_o), .tick_o(tick_o)
  );

  always #4 clk = ~clk;

  // Behavioural reference: seen-high history of the input, tick phase, quiet-tick count
  int  m_hist[$];
  int  m_phase, m_quiet;
  bit  m_st, m_fl, m_tick;

  function automatic int guard_len(input int g);
    return g * 4 + 3;
  endfunction

  always @(posedge clk) begin
    bit edge_seen, nst;
    cycles++;
    if (!rst_n) begin
      m_hist = '{0, 0, 0};
      m_phase = 0; m_quiet = 0; m_st = 1; m_fl = 0;
    end else begin
      edge_seen = (m_hist[1] == 1) && (m_hist[2] == 0);
      nst = m_st;
      if (edge_seen) begin
        nst = 0; m_quiet = 0;
      end else if (!m_st && (m_phase % PRE == PRE - 1)) begin
        m_quiet++;
        if (m_quiet >= guard_len(guard_sel)) begin nst = 1; m_quiet = 0; end
      end
      if (irq_en && (nst != m_st)) m_fl = 1;
      else if (rd_clr) m_fl = 0;
      m_st = nst;
      void'(m_hist.pop_back());
      m_hist.push_front(int'(pulse_i));
      m_phase++;
    end
    m_tick = rst_n && (m_phase % PRE == PRE - 1);
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at cycle %0d", req, what, act, exp, cycles);
    end
  endtask

  // Compare with the model on every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R2/R3/R5", "status", status_o, m_st);
      check("R6/R7/R8", "flag", flag_o, m_fl);
      check("R4", "tick", tick_o, m_tick);
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int hi, input int lo);
    @(negedge clk) pulse_i = 1'b1;
    idle(hi);
    pulse_i = 1'b0;
    idle(lo);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle(3);
    // R1 reset values
    check("R1", "reset status", status_o, 1);
    check("R1", "reset flag", flag_o, 0);
    rst_n = 1'b1;
    idle(2);

    // R2: input seen at edge k drops status after edge k+2
    irq_en = 1'b1;
    guard_sel = 7'd0;
    @(negedge clk) pulse_i = 1'b1;
    @(negedge clk); check("R2", "status after 1 edge", status_o, 1);
    @(negedge clk); check("R2", "status after 2 edges", status_o, 1);
    @(negedge clk); check("R2", "status after 3 edges", status_o, 0);
    check("R6", "flag on fall", flag_o, 1);
    // R2 falling edge has no effect: guard still expires
    pulse_i = 1'b0;
    idle(3 * PRE + 6);
    check("R3", "status back high, G=0", status_o, 1);
    @(negedge clk) rd_clr = 1'b1;
    @(negedge clk) rd_clr = 1'b0;
    check("R8", "flag cleared by read", flag_o, 0);

    // R5: ringing burst faster than guard keeps status low
    guard_sel = 7'd1;
    for (int i = 0; i < 6; i++) pulse(2, 3 * PRE);
    check("R5", "status low during burst", status_o, 0);
    idle(8 * PRE + 6);
    check("R3", "status high after G=1 guard", status_o, 1);

    // R7: transitions with enable off leave flag alone
    @(negedge clk) rd_clr = 1'b1;
    @(negedge clk) rd_clr = 1'b0;
    irq_en = 1'b0;
    pulse(2, 2);
    check("R7", "flag with enable off (fall)", flag_o, 0);
    idle(8 * PRE + 6);
    check("R7", "flag with enable off (rise)", flag_o, 0);
    check("R3", "status high again", status_o, 1);

    // R8: read-clear held across the status rise; set must win
    irq_en = 1'b1;
    guard_sel = 7'd0;
    pulse(1, 2);
    check("R6", "flag on fall before collision", flag_o, 1);
    rd_clr = 1'b1;
    idle(3 * PRE + 4);
    rd_clr = 1'b0;
    idle(1);
    check("R8", "status rose", status_o, 1);

    // Longer guard setting, then steady high input does nothing more
    guard_sel = 7'd3;
    @(negedge clk) pulse_i = 1'b1;
    idle(20 * PRE);
    check("R2", "steady high input, guard expired", status_o, 1);
    pulse_i = 1'b0;
    idle(4);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule